// File: doc/BRIEF.md
# Byte ALU with Flag Register

This block is the arithmetic and logic core of a small 8-bit processor datapath. It takes one or two byte operands and an operation code, produces the result combinationally, and keeps an 8-bit status byte in a register that changes on the clock edge where `op_valid` is high. Operand fetch, instruction decode and writing results back to a register file are the job of the surrounding datapath. The result is valid in the same cycle as the operands. The flags that result from an operation are visible from the cycle after the edge that accepts it.

The block covers the following operations:
- add and subtract, each with and without the carry flag as carry or borrow input;
- AND, OR and XOR;
- one's and two's complement;
- increment and decrement;
- logical shifts in both directions, rotates through carry and arithmetic right shift;
- nibble swap;
- adding or subtracting a 6-bit immediate to or from a 16-bit register pair.

Every operation writes only its own set of status bits. Separate set and clear operations address a single status bit by its index. A subtract with carry can only clear the zero flag, so a chain of byte-wise subtracts over a multi-byte value ends with a zero flag that describes the whole value.

Top module: `status_alu`

## Requirements
- R1: The status byte holds, from bit 7 to bit 0: I, T, H, S, V, N, Z, C. Reset clears all of it. The `flag_sel` index of a set or clear operation uses these bit positions.
- R2: OP_ADD, OP_ADC, OP_SUB and OP_SBC produce a+b, a+b+C, a-b and a-b-C modulo 256. They update C, Z, N, V, H and S. On a subtract, C is the borrow out of bit 7. I and T stay unchanged.
- R3: On add and subtract, H is the carry or borrow out of bit 3, and V is set when the signed result does not fit in 8 bits.
- R4: On OP_SBC, Z becomes 1 only when Z was already 1 and the result is zero. Otherwise Z is cleared.
- R5: OP_AND, OP_OR and OP_XOR update Z, N and S and clear V. C and H stay unchanged.
- R6: OP_INC and OP_DEC produce a+1 and a-1 modulo 256. They update Z, N, V and S. V is set when the result is 0x80 after an increment or 0x7F after a decrement. C and H stay unchanged.
- R7: OP_COM gives 0xFF-a, sets C and clears V. OP_NEG gives 0x00-a. It sets C when the result is nonzero, sets H on a borrow out of bit 3, and sets V when the result is 0x80. Both update Z, N and S. OP_COM leaves H unchanged.
- R8: OP_LSL, OP_LSR, OP_ROL, OP_ROR and OP_ASR each shift by one place, and C receives the bit shifted out. Rotates feed the old C into the vacant bit, and OP_ASR keeps bit 7. They update Z and N, set V to N xor C, and update S. H stays unchanged.
- R9: OP_SWAP exchanges the two nibbles of a and leaves the whole status byte unchanged.
- R10: OP_WADD and OP_WSUB add or subtract `word_imm` to or from the pair {b,a}. The 16-bit result appears on `res_hi`:`res_lo`. They update Z, C, N, V and S from the 16-bit value and leave H unchanged. For all byte operations `res_hi` is zero.
- R11: After any operation that updates N or V, S equals N xor V.
- R12: OP_FSET and OP_FCLR set or clear the status bit at index `flag_sel` and leave the other seven bits unchanged.
- R13: While `op_valid` is low, the status byte holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the status byte changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the status byte |
| op_valid | input | 1 | Accept the current operation into the status byte |
| op_code | input | 5 | Operation, encoded as `alu_op_e` in `status_alu_pkg` |
| opnd_a | input | W | First operand; low byte of the pair for word operations |
| opnd_b | input | W | Second operand; high byte of the pair for word operations |
| word_imm | input | IMMW | Unsigned immediate for word add and subtract |
| flag_sel | input | 3 | Status bit index for set and clear operations |
| res_lo | output | W | Result, or low byte of a word result |
| res_hi | output | W | High byte of a word result, zero otherwise |
| status | output | 8 | Registered status byte |

## Verification
On every cycle the assertions check the following:
- the status byte holds while no operation is accepted;
- a swap leaves every flag alone;
- logic, increment and decrement operations preserve C and H;
- one's complement always sets C and clears V;
- a subtract with carry never raises Z;
- a set or clear operation changes at most the one selected bit;
- S agrees with N xor V after every operation that writes them.

Only the bench's sweeps can show that the arithmetic itself is right. The bench runs every first operand against a set of boundary second operands, with both carry-in values, and compares results, half carry, signed overflow and 16-bit pair results with values it computes in integer arithmetic.

// File: rtl/status_alu_pkg.sv
package status_alu_pkg;

   // status byte bit positions
   localparam int SB_C = 0;
   localparam int SB_Z = 1;
   localparam int SB_N = 2;
   localparam int SB_V = 3;
   localparam int SB_S = 4;
   localparam int SB_H = 5;
   localparam int SB_T = 6;
   localparam int SB_I = 7;

   localparam int OP_BITS = 5;

   typedef enum logic [OP_BITS-1:0] {
      OP_ADD, OP_ADC, OP_SUB, OP_SBC,
      OP_AND, OP_OR, OP_XOR,
      OP_COM, OP_NEG, OP_INC, OP_DEC,
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_SWAP,
      OP_WADD, OP_WSUB,
      OP_FSET, OP_FCLR
   } alu_op_e;

   // which status bits an operation writes (flag set/clear handled apart)
   function automatic logic [7:0] upd_mask(alu_op_e op);
      logic [7:0] m;
      m = 8'h00;
      unique case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
            m = 8'b0011_1111;
         OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:
            m = 8'b0001_1110;
         OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_WADD, OP_WSUB:
            m = 8'b0001_1111;
         default:
            m = 8'h00;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/status_alu_addsub.sv
module status_alu_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         hcarry,
   output logic         ovf
);
   localparam int NIB = W / 2;

   logic [W-1:0] yy;
   logic [W:0]   cc;

   assign yy    = sub ? ~y : y;
   assign cc[0] = sub ? ~cin : cin;

   // ripple chain keeps the nibble and sign carries as plain taps
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]  = x[i] ^ yy[i] ^ cc[i];
      assign cc[i+1] = (x[i] & yy[i]) | (cc[i] & (x[i] ^ yy[i]));
   end

   // on subtract the chain carries "no borrow"; invert to get borrow
   assign cout   = sub ? ~cc[W]   : cc[W];
   assign hcarry = sub ? ~cc[NIB] : cc[NIB];
   assign ovf    = cc[W] ^ cc[W-1];

endmodule

// File: rtl/status_alu_bitops.sv
module status_alu_bitops
   import status_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout,
   output logic         ovf
);
   localparam int NIB = W / 2;
   localparam logic [W-1:0] ONE     = W'(1);
   localparam logic [W-1:0] MSB_SET = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAX_POS = ~MSB_SET;

   always_comb begin
      res  = a;
      cout = cin;
      ovf  = 1'b0;
      unique case (op)
         OP_AND: res = a & b;
         OP_OR:  res = a | b;
         OP_XOR: res = a ^ b;
         OP_COM: begin
            res  = ~a;
            cout = 1'b1;
         end
         OP_INC: begin
            res = a + ONE;
            ovf = (res == MSB_SET);
         end
         OP_DEC: begin
            res = a - ONE;
            ovf = (res == MAX_POS);
         end
         OP_LSL: begin
            res  = {a[W-2:0], 1'b0};
            cout = a[W-1];
         end
         OP_LSR: begin
            res  = {1'b0, a[W-1:1]};
            cout = a[0];
         end
         OP_ROL: begin
            res  = {a[W-2:0], cin};
            cout = a[W-1];
         end
         OP_ROR: begin
            res  = {cin, a[W-1:1]};
            cout = a[0];
         end
         OP_ASR: begin
            res  = {a[W-1], a[W-1:1]};
            cout = a[0];
         end
         OP_SWAP: res = {a[NIB-1:0], a[W-1:NIB]};
         default: res = a;
      endcase
      // shifts report sign change as N xor C
      if (op inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR})
         ovf = res[W-1] ^ cout;
   end

endmodule

// File: rtl/status_alu_word.sv
module status_alu_word #(
   parameter int W    = 8,
   parameter int IMMW = 6,
   parameter bit EN   = 1'b1
) (
   input  logic [W-1:0]    lo,
   input  logic [W-1:0]    hi,
   input  logic [IMMW-1:0] imm,
   input  logic            sub,
   output logic [2*W-1:0]  res,
   output logic            cout,
   output logic            ovf
);
   localparam int PW = 2 * W;

   if (EN) begin : g_on
      logic [PW-1:0] pair;
      logic [PW:0]   ext;
      logic [PW:0]   immx;

      assign pair = {hi, lo};
      assign immx = {{(PW + 1 - IMMW){1'b0}}, imm};
      assign ext  = sub ? ({1'b0, pair} - immx) : ({1'b0, pair} + immx);
      assign res  = ext[PW-1:0];
      assign cout = ext[PW];
      assign ovf  = sub ? (pair[PW-1] & ~ext[PW-1]) : (~pair[PW-1] & ext[PW-1]);
   end else begin : g_off
      logic unused_in;
      assign unused_in = ^{lo, hi, imm, sub};
      assign res  = '0;
      assign cout = 1'b0;
      assign ovf  = 1'b0;
   end

endmodule

// File: rtl/status_alu.sv
module status_alu
   import status_alu_pkg::*;
#(
   parameter int W       = 8,
   parameter int IMMW    = 6,
   parameter bit WORD_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [4:0]      op_code,
   input  logic [W-1:0]    opnd_a,
   input  logic [W-1:0]    opnd_b,
   input  logic [IMMW-1:0] word_imm,
   input  logic [2:0]      flag_sel,
   output logic [W-1:0]    res_lo,
   output logic [W-1:0]    res_hi,
   output logic [7:0]      status
);
   localparam int PW = 2 * W;

   if (W < 4 || (W % 2) != 0) begin : g_bad_w
      $error("status_alu: W must be even and at least 4");
   end
   if (IMMW < 1 || IMMW > W) begin : g_bad_imm
      $error("status_alu: IMMW must lie in 1..W");
   end

   alu_op_e opc;
   assign opc = alu_op_e'(op_code);

   logic [7:0] st_q, st_d;

   // ---------------- add / subtract unit ----------------
   logic [W-1:0] as_x, as_y, as_sum;
   logic         as_sub, as_ci, as_c, as_h, as_v;
   logic         is_as, is_word;

   assign is_as   = opc inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG};
   assign is_word = opc inside {OP_WADD, OP_WSUB};

   always_comb begin
      as_x   = opnd_a;
      as_y   = opnd_b;
      as_sub = opc inside {OP_SUB, OP_SBC, OP_NEG};
      as_ci  = (opc == OP_ADC || opc == OP_SBC) ? st_q[SB_C] : 1'b0;
      if (opc == OP_NEG) begin
         as_x = '0;
         as_y = opnd_a;
      end
   end

   status_alu_addsub #(.W(W)) u_addsub (
      .x      (as_x),
      .y      (as_y),
      .cin    (as_ci),
      .sub    (as_sub),
      .sum    (as_sum),
      .cout   (as_c),
      .hcarry (as_h),
      .ovf    (as_v)
   );

   // ---------------- logic / shift unit ----------------
   logic [W-1:0] bo_res;
   logic         bo_c, bo_v;

   status_alu_bitops #(.W(W)) u_bitops (
      .op   (opc),
      .a    (opnd_a),
      .b    (opnd_b),
      .cin  (st_q[SB_C]),
      .res  (bo_res),
      .cout (bo_c),
      .ovf  (bo_v)
   );

   // ---------------- register-pair unit ----------------
   logic [PW-1:0] wd_res;
   logic          wd_c, wd_v;

   status_alu_word #(.W(W), .IMMW(IMMW), .EN(WORD_EN)) u_word (
      .lo   (opnd_a),
      .hi   (opnd_b),
      .imm  (word_imm),
      .sub  (opc == OP_WSUB),
      .res  (wd_res),
      .cout (wd_c),
      .ovf  (wd_v)
   );

   // ---------------- result select ----------------
   always_comb begin
      if (is_word) begin
         res_lo = wd_res[W-1:0];
         res_hi = wd_res[PW-1:W];
      end else begin
         res_lo = is_as ? as_sum : bo_res;
         res_hi = '0;
      end
   end

   // ---------------- flag build and merge ----------------
   logic       f_c, f_z, f_n, f_v, f_h;
   logic [7:0] f_new, f_mask;

   always_comb begin
      f_h = st_q[SB_H];
      if (is_word) begin
         f_c = wd_c;
         f_v = wd_v;
         f_n = wd_res[PW-1];
         f_z = (wd_res == '0);
      end else if (is_as) begin
         f_c = as_c;
         f_v = as_v;
         f_h = as_h;
         f_n = as_sum[W-1];
         // multi-byte compare: Z may only fall on a carried subtract
         f_z = (as_sum == '0) && ((opc != OP_SBC) || st_q[SB_Z]);
      end else begin
         f_c = bo_c;
         f_v = bo_v;
         f_n = bo_res[W-1];
         f_z = (bo_res == '0);
      end
   end

   assign f_new  = {st_q[SB_I], st_q[SB_T], f_h, f_n ^ f_v, f_v, f_n, f_z, f_c};
   assign f_mask = upd_mask(opc);

   always_comb begin
      st_d = (st_q & ~f_mask) | (f_new & f_mask);
      if (opc == OP_FSET) st_d[flag_sel] = 1'b1;
      if (opc == OP_FCLR) st_d[flag_sel] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        st_q <= '0;
      else if (op_valid) st_q <= st_d;
   end

   assign status = st_q;

endmodule

// File: rtl/status_alu_chk.sv
module status_alu_chk
   import status_alu_pkg::*;
#(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic [4:0]   op_code,
   input logic [2:0]   flag_sel,
   input logic [W-1:0] res_lo,
   input logic [7:0]   status
);
   alu_op_e opc;
   assign opc = alu_op_e'(op_code);

   assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(status));

   assert_swap_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc == OP_SWAP) |=> $stable(status));

   assert_logic_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc inside {OP_AND, OP_OR, OP_XOR}) |=>
         (status[SB_C] == $past(status[SB_C])) && (status[SB_H] == $past(status[SB_H]))
         && !status[SB_V]);

   assert_incdec_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc inside {OP_INC, OP_DEC}) |=>
         (status[SB_C] == $past(status[SB_C])) && (status[SB_H] == $past(status[SB_H])));

   assert_com_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc == OP_COM) |=> status[SB_C] && !status[SB_V]);

   assert_sbc_zero_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc == OP_SBC && !status[SB_Z]) |=> !status[SB_Z]);

   assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc inside {OP_ADD, OP_ADC, OP_SUB}) |=>
         (status[SB_Z] == ($past(res_lo) == '0)));

   assert_sign_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !(opc inside {OP_SWAP, OP_FSET, OP_FCLR})) |=>
         (status[SB_S] == (status[SB_N] ^ status[SB_V])));

   assert_flag_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc == OP_FSET) |=>
         status[$past(flag_sel)] && ($countones(status ^ $past(status)) <= 1));

   assert_flag_clr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opc == OP_FCLR) |=>
         !status[$past(flag_sel)] && ($countones(status ^ $past(status)) <= 1));

endmodule

bind status_alu status_alu_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_code  (op_code),
   .flag_sel (flag_sel),
   .res_lo   (res_lo),
   .status   (status)
);

// File: tb/status_alu_test.sv
module status_alu_test;
   import status_alu_pkg::*;

   localparam int CLK_P = 10;
   localparam int WDOG  = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_code = '0;
   logic [7:0] opnd_a = '0;
   logic [7:0] opnd_b = '0;
   logic [5:0] word_imm = '0;
   logic [2:0] flag_sel = '0;
   logic [7:0] res_lo, res_hi, status;

   int         checks = 0;
   int         errors = 0;
   logic [7:0] exp_st = '0;
   bit         finished = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   status_alu uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .word_imm(word_imm), .flag_sel(flag_sel),
      .res_lo(res_lo), .res_hi(res_hi), .status(status)
   );

   function automatic string req_of(alu_op_e o);
      case (o)
         OP_ADD, OP_ADC, OP_SUB: return "R2/R3";
         OP_SBC:                 return "R2/R3/R4";
         OP_AND, OP_OR, OP_XOR:  return "R5";
         OP_INC, OP_DEC:         return "R6";
         OP_COM, OP_NEG:         return "R7";
         OP_SWAP:                return "R9";
         OP_WADD, OP_WSUB:       return "R10";
         OP_FSET, OP_FCLR:       return "R12";
         default:                return "R8";
      endcase
   endfunction

   // expected {res_hi, res_lo, status}, computed in integer arithmetic
   function automatic logic [23:0] model(alu_op_e o, int a, int b, int imm, int sel,
                                         logic [7:0] st);
      int t, r, hi, ci, sa, sb, sv, p, cin;
      logic c, h, v, n, z, uc, uh, keep, wrd, sticky;
      logic [7:0] ns;
      ns = st; cin = int'(st[0]);
      t = 0; r = 0; hi = 0; ci = 0; p = 0; sv = 0;
      c = 1'b0; h = 1'b0; v = 1'b0; uc = 1'b0; uh = 1'b0;
      keep = 1'b0; wrd = 1'b0; sticky = 1'b0;
      sa = (a > 127) ? a - 256 : a;
      sb = (b > 127) ? b - 256 : b;
      case (o)
         OP_ADD, OP_ADC: begin
            ci = (o == OP_ADC) ? cin : 0;
            t = a + b + ci; r = t % 256; c = (t > 255);
            h = ((a % 16) + (b % 16) + ci) > 15;
            sv = sa + sb + ci; v = (sv > 127) || (sv < -128);
            uc = 1'b1; uh = 1'b1;
         end
         OP_SUB, OP_SBC: begin
            ci = (o == OP_SBC) ? cin : 0;
            t = a - b - ci; r = (t + 512) % 256; c = (t < 0);
            h = (a % 16) < ((b % 16) + ci);
            sv = sa - sb - ci; v = (sv > 127) || (sv < -128);
            uc = 1'b1; uh = 1'b1; sticky = (o == OP_SBC);
         end
         OP_NEG: begin
            r = (256 - a) % 256; c = (a != 0); h = (a % 16) != 0; v = (a == 128);
            uc = 1'b1; uh = 1'b1;
         end
         OP_AND: r = a & b;
         OP_OR:  r = a | b;
         OP_XOR: r = a ^ b;
         OP_COM: begin r = 255 - a; c = 1'b1; uc = 1'b1; end
         OP_INC: begin r = (a + 1) % 256; v = (a == 127); end
         OP_DEC: begin r = (a + 255) % 256; v = (a == 128); end
         OP_LSL: begin r = (a * 2) % 256; c = (a >= 128); uc = 1'b1; end
         OP_LSR: begin r = a / 2; c = (a % 2) != 0; uc = 1'b1; end
         OP_ROL: begin r = (a * 2) % 256 + cin; c = (a >= 128); uc = 1'b1; end
         OP_ROR: begin r = a / 2 + cin * 128; c = (a % 2) != 0; uc = 1'b1; end
         OP_ASR: begin r = a / 2 + (a / 128) * 128; c = (a % 2) != 0; uc = 1'b1; end
         OP_SWAP: begin r = (a % 16) * 16 + a / 16; keep = 1'b1; end
         OP_WADD: begin
            p = b * 256 + a; t = p + imm; c = (t > 65535); t = t % 65536;
            v = (p < 32768) && (t >= 32768); uc = 1'b1; wrd = 1'b1;
         end
         OP_WSUB: begin
            p = b * 256 + a; t = p - imm; c = (t < 0); t = (t + 65536) % 65536;
            v = (p >= 32768) && (t < 32768); uc = 1'b1; wrd = 1'b1;
         end
         OP_FSET: begin ns[sel] = 1'b1; keep = 1'b1; end
         OP_FCLR: begin ns[sel] = 1'b0; keep = 1'b1; end
         default: keep = 1'b1;
      endcase
      if (wrd) begin
         n = (t >= 32768); z = (t == 0); hi = t / 256; r = t % 256;
      end else begin
         n = (r >= 128); z = (r == 0);
         if (sticky) z = z && st[1];
      end
      if (o inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR}) v = n ^ c;
      if (!keep) begin
         ns[2] = n; ns[1] = z; ns[3] = v; ns[4] = n ^ v;
         if (uc) ns[0] = c;
         if (uh) ns[5] = h;
      end
      return {8'(hi), 8'(r), ns};
   endfunction

   task automatic check(string tag, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
      end
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic do_op(alu_op_e o, int a, int b, int imm, int sel);
      logic [23:0] e;
      string tag;
      e = model(o, a, b, imm, sel, exp_st);
      tag = $sformatf("%s op=%0d a=%h b=%h imm=%0d st=%h", req_of(o), int'(o), a, b, imm, exp_st);
      op_code  = o;
      opnd_a   = 8'(a);
      opnd_b   = 8'(b);
      word_imm = 6'(imm);
      flag_sel = 3'(sel);
      op_valid = 1'b1;
      #1;
      if (!(o inside {OP_FSET, OP_FCLR})) begin
         check(tag, "res_lo", int'(res_lo), int'(e[15:8]));
         check(tag, "res_hi", int'(res_hi), int'(e[23:16]));
      end
      @(negedge clk);
      op_valid = 1'b0;
      check(tag, "status", int'(status), int'(e[7:0]));
      exp_st = e[7:0];
   endtask

   task automatic set_carry(int cv);
      do_op(cv != 0 ? OP_FSET : OP_FCLR, 0, 0, 0, 0);
   endtask

   task automatic idle_cycle(alu_op_e o, int a);
      op_valid = 1'b0;
      op_code  = o;
      opnd_a   = 8'(a);
      flag_sel = 3'(a % 8);
      @(negedge clk);
      check("R13 idle", "status", int'(status), int'(exp_st));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired after %0d cycles", WDOG);
      finish_run();
   end

   initial begin
      int bv[16] = '{0, 1, 2, 7, 8, 15, 16, 'h3F, 'h40, 'h7E, 'h7F, 'h80, 'h81, 'hF0, 'hFE, 'hFF};
      alu_op_e arith[4] = '{OP_ADD, OP_ADC, OP_SUB, OP_SBC};
      alu_op_e logicv[3] = '{OP_AND, OP_OR, OP_XOR};
      alu_op_e unary[10] = '{OP_COM, OP_NEG, OP_INC, OP_DEC, OP_LSL,
                             OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_SWAP};

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 in reset", "status", int'(status), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", "status", int'(status), 0);

      // R12: each bit set then cleared alone; R1 positions
      for (int s = 0; s < 8; s++) do_op(OP_FSET, 0, 0, 0, s);
      for (int s = 0; s < 8; s++) do_op(OP_FCLR, 0, 0, 0, s);
      do_op(OP_FSET, 0, 0, 0, SB_I);
      do_op(OP_FSET, 0, 0, 0, SB_T);
      idle_cycle(OP_FCLR, 7);

      // R2, R3, R4: add/subtract sweep with both carry inputs
      foreach (arith[k]) begin
         for (int a = 0; a < 256; a++) begin
            for (int j = 0; j < 16; j++) begin
               for (int cv = 0; cv < 2; cv++) begin
                  set_carry(cv);
                  do_op(arith[k], a, bv[j], 0, 0);
               end
            end
         end
      end

      // R4: multi-byte compare chain keeps Z only through equal bytes
      do_op(OP_SUB, 'h34, 'h34, 0, 0);
      do_op(OP_SBC, 'h12, 'h12, 0, 0);
      check("R4 equal chain", "Z", int'(status[SB_Z]), 1);
      do_op(OP_SUB, 'h35, 'h34, 0, 0);
      do_op(OP_SBC, 'h12, 'h12, 0, 0);
      check("R4 unequal low byte", "Z", int'(status[SB_Z]), 0);

      // R5: logic operations
      foreach (logicv[k])
         for (int a = 0; a < 256; a++)
            for (int j = 0; j < 16; j++)
               do_op(logicv[k], a, bv[j], 0, 0);

      // R6, R7, R8, R9, R11: single-operand operations with both carry inputs
      foreach (unary[k]) begin
         for (int a = 0; a < 256; a++) begin
            for (int cv = 0; cv < 2; cv++) begin
               set_carry(cv);
               do_op(unary[k], a, 'h5A, 0, 0);
            end
         end
      end
      idle_cycle(OP_ADD, 3);

      // R10: word add/subtract of every immediate on boundary pairs
      for (int hk = 0; hk < 4; hk++) begin
         for (int lk = 0; lk < 16; lk++) begin
            for (int imm = 0; imm < 64; imm++) begin
               do_op(OP_WADD, bv[lk], bv[(hk * 5) % 16 + (hk == 3 ? 0 : 0)], imm, 0);
               do_op(OP_WSUB, bv[lk], bv[(hk * 5) % 16], imm, 0);
            end
         end
      end
      do_op(OP_WADD, 'hFF, 'hFF, 1, 0);
      check("R10 wrap to zero", "Z and C", int'(status[1:0]), 3);
      do_op(OP_WSUB, 'h00, 'h80, 1, 0);
      check("R10 signed overflow", "V", int'(status[SB_V]), 1);

      // R13: idle cycles with changing inputs
      idle_cycle(OP_FSET, 5);
      idle_cycle(OP_COM, 0);

      finish_run();
   end

endmodule